// File: doc/BRIEF.md
# Serial five-bit CRC generator

This block computes a five-bit cyclic redundancy check over a serial bit stream, most significant bit first. The generator polynomial is x^5 + x^2 + x + 1, coefficients 100111. A start strobe opens a message. Each cycle in which the bit-valid strobe is high, one data bit enters. Once a fixed number of message bits (parameter `MSG_BITS`, default 8) has been taken, the block raises a one-cycle done flag. The five-bit result then stays on the output until the next start.

The shift structure is chosen at elaboration. In the direct form, each incoming bit is folded into the feedback term, so the remainder is ready right after the last message bit. The augmented form works like long division: the register shifts the data in as its low bit and subtracts the polynomial whenever a one falls off the top. It therefore needs five zero bits after the message. The block supplies those zeros itself, one per cycle, with no bit-valid strobe needed. Both forms produce the same remainder, and the augmented form finishes five cycles later.

Top module: `serial_crc5`

## Requirements
- R1: While reset is asserted and after it is released, the CRC output is 00000 and the done flag is low.
- R2: In the direct form, the register {c4..c0} takes {c3, c2, c1^c4^D, c0^c4^D, c4^D} on each accepted bit D. After MSG_BITS bits the output equals (M·x^5) mod (x^5+x^2+x+1), where M is the message taken MSB first.
- R3: The augmented form gives the same remainder as R2 for every message. It does this by shifting D in as the LSB and XOR-ing 00111 whenever the bit shifted out is 1, then shifting in five zero bits.
- R4: In the direct form, the done flag is high for exactly one cycle: the cycle right after the clock edge that accepts the last message bit.
- R5: In the augmented form, the done flag is high for exactly one cycle, five cycles later than in R4. Bit-valid strobes during the five padding cycles have no effect.
- R6: When start is high, the register and the bit counter are cleared. If bit-valid is also high in that cycle, the bit is taken as the first message bit. A start during a message or during padding discards that earlier work.
- R7: A cycle inside a message with bit-valid low changes neither the register nor the bit count.
- R8: After done, and after reset before any start, the CRC output holds its value and bit-valid strobes are ignored until the next start.
- R9: The message 10010011 gives 01010 in both forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| start_i | input | 1 | Clears the register and counter and opens a new message |
| bit_vld_i | input | 1 | Marks bit_i as a message bit in this cycle |
| bit_i | input | 1 | Serial data bit, MSB of the message first |
| crc_o | output | 5 | Current CRC register contents |
| done_o | output | 1 | One-cycle pulse when the remainder is final |

## Verification
The hardest case to reach is a bit-valid strobe that arrives while the augmented form is still padding, or after it has gone idle. A correct design ignores that bit, but a faulty one would silently mix it into the remainder. The stimulus keeps bit-valid high with a data value of one after every message in the sweep, and it also restarts messages in the middle of the data and in the middle of the padding. Two instances, one of each form, run side by side over all 256 eight-bit messages, both with and without gaps between bits. Each result is compared against a remainder that the bench computes by polynomial long division.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

  // Architecture selectors
  localparam int ARCH_DIRECT  = 0;
  localparam int ARCH_AUGMENT = 1;

  // Sequencer phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MSG  = 2'd1,
    PH_PAD  = 2'd2
  } phase_t;

endpackage

// File: rtl/crc5_step_direct.sv
// One shift of the direct form: the data bit joins the feedback term.
module crc5_step_direct #(
  parameter int               WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY  = 5'b00111
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] nxt_o
);

  logic fb;

  always_comb begin
    fb    = cur_i[WIDTH-1] ^ din_i;
    nxt_o = {cur_i[WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

endmodule

// File: rtl/crc5_step_augment.sv
// One shift of the division form: the data bit enters as LSB, the
// bit leaving the top decides whether the divisor is subtracted.
module crc5_step_augment #(
  parameter int               WIDTH = 5,
  parameter logic [WIDTH-1:0] POLY  = 5'b00111
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             din_i,
  output logic [WIDTH-1:0] nxt_o
);

  logic out_bit;

  always_comb begin
    out_bit = cur_i[WIDTH-1];
    nxt_o   = {cur_i[WIDTH-2:0], din_i} ^ (out_bit ? POLY : '0);
  end

endmodule

// File: rtl/crc5_seq_ctrl.sv
// Counts shifts, inserts the zero padding in the division form and
// produces the done pulse.
module crc5_seq_ctrl
  import crc5_pkg::*;
#(
  parameter int WIDTH    = 5,
  parameter int MSG_BITS = 8,
  parameter int ARCH     = ARCH_DIRECT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  output logic clr_o,
  output logic shift_en_o,
  output logic shift_bit_o,
  output logic done_o
);

  localparam int PAD_BITS = (ARCH == ARCH_AUGMENT) ? WIDTH : 0;
  localparam int TOTAL    = MSG_BITS + PAD_BITS;
  localparam int CNT_W    = $clog2(TOTAL + 1);

  phase_t             phase_q, phase_d, phase_base;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_base, cnt_inc;
  logic               done_q, done_d;
  logic               ctl_en;

  // Next-state logic
  always_comb begin
    clr_o       = start_i;
    phase_base  = start_i ? PH_MSG : phase_q;
    cnt_base    = start_i ? '0 : cnt_q;
    shift_en_o  = 1'b0;
    shift_bit_o = 1'b0;

    unique case (phase_base)
      PH_MSG: begin
        shift_en_o  = bit_vld_i;
        shift_bit_o = bit_i;
      end
      PH_PAD: begin
        shift_en_o  = 1'b1;
        shift_bit_o = 1'b0;
      end
      default: begin
        shift_en_o  = 1'b0;
        shift_bit_o = 1'b0;
      end
    endcase

    cnt_inc = cnt_base + CNT_W'(1);
    cnt_d   = shift_en_o ? cnt_inc : cnt_base;
    done_d  = shift_en_o && (cnt_inc == CNT_W'(TOTAL));

    phase_d = phase_base;
    if (done_d) begin
      phase_d = PH_IDLE;
    end else if (shift_en_o && (phase_base == PH_MSG) &&
                 (cnt_inc == CNT_W'(MSG_BITS))) begin
      phase_d = PH_PAD;
    end

    ctl_en = start_i | shift_en_o;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (ctl_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/crc5_state_reg.sv
// Remainder register with clear and shift enable.
module crc5_state_reg #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_en_i,
  input  logic [WIDTH-1:0] step_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] base_o
);

  logic [WIDTH-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    base_o = clr_i ? '0 : rem_q;
    rem_d  = shift_en_i ? step_i : base_o;
    rem_en = clr_i | shift_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign cur_o = rem_q;

endmodule

// File: rtl/serial_crc5.sv
module serial_crc5
  import crc5_pkg::*;
#(
  parameter int               WIDTH    = 5,
  parameter logic [WIDTH-1:0] POLY     = 5'b00111,
  parameter int               MSG_BITS = 8,
  parameter int               ARCH     = ARCH_DIRECT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] crc_o,
  output logic             done_o
);

  logic             clr;
  logic             shift_en;
  logic             shift_bit;
  logic [WIDTH-1:0] rem_base;
  logic [WIDTH-1:0] rem_step;

  crc5_seq_ctrl #(
    .WIDTH    (WIDTH),
    .MSG_BITS (MSG_BITS),
    .ARCH     (ARCH)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bit_vld_i   (bit_vld_i),
    .bit_i       (bit_i),
    .clr_o       (clr),
    .shift_en_o  (shift_en),
    .shift_bit_o (shift_bit),
    .done_o      (done_o)
  );

  generate
    if (ARCH == ARCH_AUGMENT) begin : g_aug
      crc5_step_augment #(
        .WIDTH (WIDTH),
        .POLY  (POLY)
      ) u_step (
        .cur_i (rem_base),
        .din_i (shift_bit),
        .nxt_o (rem_step)
      );
    end else begin : g_dir
      crc5_step_direct #(
        .WIDTH (WIDTH),
        .POLY  (POLY)
      ) u_step (
        .cur_i (rem_base),
        .din_i (shift_bit),
        .nxt_o (rem_step)
      );
    end
  endgenerate

  crc5_state_reg #(
    .WIDTH (WIDTH)
  ) u_rem (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .shift_en_i (shift_en),
    .step_i     (rem_step),
    .cur_o      (crc_o),
    .base_o     (rem_base)
  );

endmodule

// File: rtl/serial_crc5_chk.sv
module serial_crc5_chk
  import crc5_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int ARCH  = ARCH_DIRECT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             bit_vld_i,
  input logic [WIDTH-1:0] crc_o,
  input logic             done_o
);

  logic settled_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settled_q <= 1'b1;
    end else if (start_i) begin
      settled_q <= 1'b0;
    end else if (done_o) begin
      settled_q <= 1'b1;
    end
  end

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !done_o);

  // R8
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o || settled_q) && !start_i) |=> ($stable(crc_o) && !done_o));

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !bit_vld_i) |=> (crc_o == '0 && !done_o));

  generate
    if (ARCH == ARCH_AUGMENT) begin : g_aug
      // R5
      pad_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !$past(start_i));
    end else begin : g_dir
      // R4
      done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(bit_vld_i));
    end
  endgenerate

endmodule

bind serial_crc5 serial_crc5_chk #(
  .WIDTH (WIDTH),
  .ARCH  (ARCH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .bit_vld_i (bit_vld_i),
  .crc_o     (crc_o),
  .done_o    (done_o)
);

// File: tb/serial_crc5_bench.sv
module serial_crc5_bench;
  import crc5_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 8;
  localparam int PAD        = 5;
  localparam int RUN_CYC    = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [4:0] crc_d, crc_a;
  logic       done_d, done_a;

  int n_checks = 0;
  int n_fail   = 0;
  bit ended    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_crc5 #(.MSG_BITS(NB), .ARCH(ARCH_DIRECT)) u_serial_crc5 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .crc_o(crc_d), .done_o(done_d)
  );

  serial_crc5 #(.MSG_BITS(NB), .ARCH(ARCH_AUGMENT)) u_serial_crc5_aug (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_vld_i(bit_vld_i),
    .bit_i(bit_i), .crc_o(crc_a), .done_o(done_a)
  );

  // Remainder of m * x^5 divided by 100111, by long division
  function automatic logic [4:0] ref_crc(input logic [7:0] m);
    logic [12:0] v;
    v = {m, 5'b0};
    for (int i = 12; i >= 5; i--) begin
      if (v[i]) v = v ^ (13'b100111 << (i - 5));
    end
    return v[4:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // One message: start with first bit in cycle 0, gaps where gap_mask
  // is set, tail_vld drives bit-valid with data 1 after the message.
  task automatic run_msg(input logic [7:0] msg, input logic [31:0] gap_mask,
                         input bit tail_vld, input string ctx);
    int sent = 0;
    int last_p = -1;
    int nd = 0, na = 0;
    int cd = -1, ca = -1;
    logic [4:0] exp_crc;
    exp_crc = ref_crc(msg);
    for (int cyc = 0; cyc < RUN_CYC; cyc++) begin
      @(negedge clk);
      if (cyc > 0) begin
        if (done_d) begin
          nd++; cd = cyc - 1;
          chk(crc_d == exp_crc, {"R2 direct crc ", ctx}, crc_d, exp_crc);
        end
        if (done_a) begin
          na++; ca = cyc - 1;
          chk(crc_a == exp_crc, {"R3 augmented crc ", ctx}, crc_a, exp_crc);
        end
      end
      start_i = (cyc == 0);
      if (sent < NB && !gap_mask[cyc]) begin
        bit_vld_i = 1'b1;
        bit_i     = msg[NB-1-sent];
        sent++;
        if (sent == NB) last_p = cyc;
      end else if (sent < NB) begin
        bit_vld_i = 1'b0;   // R7 gap inside message
        bit_i     = 1'b1;
      end else begin
        bit_vld_i = tail_vld; // R5 and R8: ignored strobes
        bit_i     = 1'b1;
      end
    end
    @(negedge clk);
    start_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    chk(nd == 1 && cd == last_p, {"R4 direct done cycle ", ctx}, cd, last_p);
    chk(na == 1 && ca == last_p + PAD, {"R5 augmented done cycle ", ctx}, ca, last_p + PAD);
    chk(crc_d == exp_crc, {"R8 direct hold ", ctx}, crc_d, exp_crc);
    chk(crc_a == exp_crc, {"R8 augmented hold ", ctx}, crc_a, exp_crc);
  endtask

  // Partial message that is later abandoned by a new start
  task automatic partial(input int nbits, input int extra);
    for (int c = 0; c < nbits + extra; c++) begin
      @(negedge clk);
      start_i   = (c == 0);
      bit_vld_i = (c < nbits);
      bit_i     = 1'b1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(crc_d == 5'd0 && !done_d, "R1 direct reset", crc_d, 0);
    chk(crc_a == 5'd0 && !done_a, "R1 augmented reset", crc_a, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(crc_d == 5'd0 && !done_d, "R1 direct after release", crc_d, 0);
    chk(crc_a == 5'd0 && !done_a, "R1 augmented after release", crc_a, 0);

    // R8: strobes before any start are ignored
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      bit_vld_i = 1'b1; bit_i = 1'b1;
    end
    @(negedge clk);
    bit_vld_i = 1'b0;
    chk(crc_d == 5'd0 && !done_d, "R8 direct idle ignores bits", crc_d, 0);
    chk(crc_a == 5'd0 && !done_a, "R8 augmented idle ignores bits", crc_a, 0);

    // R9: worked example
    run_msg(8'b10010011, 32'h0, 1'b0, "R9 example");
    chk(crc_d == 5'b01010, "R9 direct example", crc_d, 5'b01010);
    chk(crc_a == 5'b01010, "R9 augmented example", crc_a, 5'b01010);

    // R2 R3: full sweep, back to back, strobes held high afterwards
    for (int m = 0; m < 256; m++) run_msg(8'(m), 32'h0, 1'b1, "sweep");

    // R7: sweep with gaps between bits
    for (int m = 0; m < 256; m++) run_msg(8'(m), 32'h0000_0264, 1'b0, "R7 gaps");

    // R6: restart in the middle of the data
    partial(4, 0);
    run_msg(8'hA5, 32'h0, 1'b0, "R6 restart in data");
    // R6: restart during padding of the division form
    partial(8, 2);
    run_msg(8'h3C, 32'h0, 1'b1, "R6 restart in padding");
    // R6: start without a bit clears the register
    @(negedge clk);
    start_i = 1'b1; bit_vld_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(crc_d == 5'd0 && !done_d, "R6 direct clear", crc_d, 0);
    chk(crc_a == 5'd0 && !done_a, "R6 augmented clear", crc_a, 0);

    finish_run();
  end

endmodule